// File: doc/BRIEF.md
# Line-Burst Pixel FIFO Read Scheduler

This block sits in the local processing clock domain and drains an external dual-clock pixel FIFO. Pixels arrive from a faster byte-rate source and have already been packed into 24-bit words. The local clock has slightly more bandwidth than the input, so the block does not read whenever data is present. It waits until the FIFO holds at least a set number of words. It then reads exactly one image line back to back and stops. Each line therefore leaves as an unbroken run of valid pixels, and the idle time between runs serves as horizontal blanking.

The frame sync from the pixel domain passes through a two-stage synchronizer and a delay line. Its rising edge produces a frame-sync pulse of fixed width, measured in local clocks. The same edges drive a small frame counter, and an image-enable flag rises once four frames have gone by. Read requests are held off while the FIFO reports empty. If the FIFO runs dry in the middle of a line, a sticky underrun flag is set and the burst resumes when data returns.

Top module: `line_burst_reader`

## Requirements
- R1: While reset is asserted, fifo_rd, pix_valid, pix_data, frame_sync, img_en and underrun are all 0.
- R2: A burst starts only when, in the cycle before the request rises, fifo_level is at least TRIG and fifo_empty is 0. Below TRIG no read is issued.
- R3: Every burst issues exactly LINE_W reads. In the cycle after the last read of a burst, fifo_rd is low, so pix_valid runs are exactly LINE_W cycles long with at least one idle cycle between them.
- R4: fifo_rd is never high while fifo_empty is high. A burst that is stalled by an empty FIFO resumes when data arrives and still totals LINE_W reads.
- R5: underrun becomes 1 when a burst is pending while the FIFO is empty. It stays 1 until reset and stays 0 when no such stall happens.
- R6: The FIFO delivers a word one clock after it is read. pix_valid equals fifo_rd delayed by two clocks, and pix_data carries the FIFO words in write order.
- R7: Take vsync_in rising before clock edge 1. frame_sync then rises at clock edge 4 and stays high for exactly SYNC_LEN clocks.
- R8: img_en rises together with the fourth frame_sync pulse after reset and stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_level | input | LVL_W | Read-side fill count of the pixel FIFO |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_q | input | PIX_W | FIFO read data, valid one clock after a read |
| vsync_in | input | 1 | Frame sync from the pixel domain, active high, asynchronous |
| fifo_rd | output | 1 | FIFO read request |
| pix_data | output | PIX_W | Output pixel word |
| pix_valid | output | 1 | Output pixel valid |
| frame_sync | output | 1 | Regenerated frame-sync pulse |
| img_en | output | 1 | Image enable, set after four frames |
| underrun | output | 1 | Sticky flag: FIFO ran empty during a burst |

## Verification
A frame-sync edge can be detected in the same cycle that a burst ends or a new one starts. Two things can also coincide: the end of one line, and a start decision taken on a FIFO level that has just been topped up. To provoke this, the FIFO is kept streaming at full rate and then at two-thirds rate while six sync pulses are injected at arbitrary phases. Each pulse is judged by its exact start cycle and width. The video path is judged at the same time by unbroken data order, exact run lengths and the single idle cycle after every line.

// File: rtl/line_burst_reader.sv
`timescale 1ns/1ps
module line_burst_reader #(
  parameter int PIX_W    = 24,
  parameter int LINE_W   = 640,
  parameter int TRIG     = 250,
  parameter int LVL_W    = 10,
  parameter int SYNC_LEN = 100,
  localparam int CNT_W   = $clog2(LINE_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             fifo_empty,
  input  logic [PIX_W-1:0] fifo_q,
  input  logic             vsync_in,
  output logic             fifo_rd,
  output logic [PIX_W-1:0] pix_data,
  output logic             pix_valid,
  output logic             frame_sync,
  output logic             img_en,
  output logic             underrun
);

  logic             rd_q;
  logic [CNT_W-1:0] rd_cnt;
  logic             rd_d1;
  logic             vs_s1, vs_s2;
  logic [SYNC_LEN+1:0] vs_sh;
  logic [1:0]       frame_cnt;

  assign fifo_rd = rd_q & ~fifo_empty;

  wire line_end  = fifo_rd && (rd_cnt == CNT_W'(LINE_W - 1));
  wire can_start = (fifo_level >= LVL_W'(TRIG)) && !fifo_empty;
  wire sync_edge = vs_sh[0] & ~vs_sh[1];
  wire sync_tail = vs_sh[SYNC_LEN] & ~vs_sh[SYNC_LEN+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      rd_cnt <= '0;
    end else if (!rd_q) begin
      rd_cnt <= '0;
      if (can_start) rd_q <= 1'b1;
    end else if (line_end) begin
      rd_q   <= 1'b0;
      rd_cnt <= '0;
    end else if (fifo_rd) begin
      rd_cnt <= rd_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_d1     <= 1'b0;
      pix_valid <= 1'b0;
      pix_data  <= '0;
      underrun  <= 1'b0;
    end else begin
      rd_d1     <= fifo_rd;
      pix_valid <= rd_d1;
      pix_data  <= fifo_q;
      if (rd_q && fifo_empty) underrun <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_s1      <= 1'b0;
      vs_s2      <= 1'b0;
      vs_sh      <= '0;
      frame_sync <= 1'b0;
      frame_cnt  <= '0;
      img_en     <= 1'b0;
    end else begin
      vs_s1 <= vsync_in;
      vs_s2 <= vs_s1;
      vs_sh <= {vs_sh[SYNC_LEN:0], vs_s2};
      if (sync_edge)      frame_sync <= 1'b1;
      else if (sync_tail) frame_sync <= 1'b0;
      if (sync_edge) begin
        frame_cnt <= frame_cnt + 1'b1;
        if (frame_cnt == 2'd3) img_en <= 1'b1;
      end
    end
  end

  p_no_read_when_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);

  p_start_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_q) |-> ($past(fifo_level) >= LVL_W'(TRIG)));

  p_gap_after_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> !fifo_rd);

  p_valid_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid == $past(fifo_rd, 2));

  p_underrun_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  p_sync_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_edge |=> frame_sync);

  p_img_en_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    img_en |=> img_en);

endmodule

// File: tb/line_burst_reader_tb.sv
`timescale 1ns/1ps
module line_burst_reader_tb;
  localparam int LW = 16, TR = 8, SL = 8, LVLW = 7, DEPTH = 64, PW = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [LVLW-1:0] fifo_level;
  logic            fifo_empty;
  logic [PW-1:0]   fifo_q;
  logic            vsync_in = 1'b0;
  logic            fifo_rd, pix_valid, frame_sync, img_en, underrun;
  logic [PW-1:0]   pix_data;

  line_burst_reader #(.PIX_W(PW), .LINE_W(LW), .TRIG(TR), .LVL_W(LVLW), .SYNC_LEN(SL)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .fifo_empty(fifo_empty),
    .fifo_q(fifo_q), .vsync_in(vsync_in), .fifo_rd(fifo_rd), .pix_data(pix_data),
    .pix_valid(pix_valid), .frame_sync(frame_sync), .img_en(img_en), .underrun(underrun));

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [PW-1:0] word(input int i);
    return {i[7:0], 8'(i * 3 + 1), i[7:0] ^ 8'hA5};
  endfunction

  logic [PW-1:0]   mem [DEPTH];
  logic [5:0]      wp, rp;
  logic [LVLW-1:0] cnt;
  int widx, ph;
  int wr_goal = 0, wr_mode = 1;

  assign fifo_level = cnt;
  assign fifo_empty = (cnt == 0);

  always @(posedge clk or negedge rst_n) begin : fifo_model
    logic w;
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; fifo_q <= '0; widx <= 0; ph <= 0;
    end else begin
      w = (widx < wr_goal) && (cnt < LVLW'(DEPTH)) && (wr_mode == 1 || ph != 2);
      ph <= (ph == 2) ? 0 : ph + 1;
      if (w) begin
        mem[wp] <= word(widx);
        wp <= wp + 1'b1;
        widx <= widx + 1;
      end
      if (fifo_rd) begin
        fifo_q <= mem[rp];
        rp <= rp + 1'b1;
      end
      cnt <= cnt + LVLW'(w) - LVLW'(fifo_rd);
    end
  end

  int burst_reads, total_reads, lines_done, ridx, run;
  bit after_end, rd_h1, rd_h2, runs_on = 0, any_rd;
  logic [LVLW-1:0] last_level;

  always @(negedge clk) begin
    if (!rst_n) begin
      burst_reads = 0; total_reads = 0; lines_done = 0; ridx = 0; run = 0;
      after_end = 0; rd_h1 = 0; rd_h2 = 0; last_level = '0;
    end else begin
      if (fifo_rd && fifo_empty) chk(0, "R4 read while empty", 1, 0);
      if (fifo_rd) any_rd = 1;
      if (after_end) chk(!fifo_rd, "R3 idle cycle after line", 32'(fifo_rd), 0);
      after_end = 0;
      if (fifo_rd) begin
        if (burst_reads == 0) chk(last_level >= LVLW'(TR), "R2 start level", 32'(last_level), TR);
        burst_reads++;
        total_reads++;
        if (burst_reads == LW) begin
          burst_reads = 0;
          after_end = 1;
          lines_done++;
        end
      end
      chk(pix_valid == rd_h2, "R6 valid lag", 32'(pix_valid), 32'(rd_h2));
      rd_h2 = rd_h1;
      rd_h1 = fifo_rd;
      if (pix_valid) begin
        chk(pix_data == word(ridx), "R6 data order", pix_data, word(ridx));
        ridx++;
        run++;
      end else begin
        if (run != 0 && runs_on) chk(run == LW, "R3 run length", run, LW);
        run = 0;
      end
      last_level = fifo_level;
    end
  end

  initial begin
    #500000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!fifo_rd && !pix_valid && pix_data == 0, "R1 reset video", {fifo_rd, pix_valid, pix_data[7:0]}, 0);
    chk(!frame_sync && !img_en && !underrun, "R1 reset flags", {frame_sync, img_en, underrun}, 0);
    rst_n = 1'b1;

    any_rd = 0;
    wr_goal = TR - 1;
    repeat (40) @(negedge clk);
    chk(!any_rd, "R2 no read below threshold", 32'(any_rd), 0);
    chk(underrun == 0, "R5 clear before stall", 32'(underrun), 0);

    wr_goal = TR;
    repeat (40) @(negedge clk);
    chk(total_reads == TR, "R4 stalled at empty", total_reads, TR);
    chk(!fifo_rd, "R4 no request while empty", 32'(fifo_rd), 0);
    chk(underrun == 1, "R5 underrun set", 32'(underrun), 1);

    wr_goal = LW;
    repeat (60) @(negedge clk);
    chk(total_reads == LW, "R4 resumed line total", total_reads, LW);
    chk(lines_done == 1, "R3 one line completed", lines_done, 1);
    chk(ridx == LW, "R6 words delivered", ridx, LW);
    chk(underrun == 1, "R5 underrun sticky", 32'(underrun), 1);

    rst_n = 1'b0;
    wr_goal = 0;
    repeat (2) @(negedge clk);
    chk(!underrun && !pix_valid && !fifo_rd, "R1 second reset", {underrun, pix_valid, fifo_rd}, 0);
    rst_n = 1'b1;
    runs_on = 1;
    wr_mode = 1;
    wr_goal = 100000;
    repeat (60) @(negedge clk);

    for (int p = 1; p <= 6; p++) begin
      int first, width;
      if (p == 3) wr_mode = 2;
      first = 0;
      width = 0;
      vsync_in = 1'b1;
      for (int k = 1; k <= SL + 12; k++) begin
        @(negedge clk);
        if (frame_sync) begin
          if (first == 0) first = k;
          width++;
        end
        if (k == 15) vsync_in = 1'b0;
      end
      chk(first == 4, "R7 pulse start", first, 4);
      chk(width == SL, "R7 pulse width", width, SL);
      chk(img_en == (p >= 4), "R8 image enable", 32'(img_en), 32'(p >= 4));
      repeat (10 + p) @(negedge clk);
    end
    chk(underrun == 0, "R5 no false underrun", 32'(underrun), 0);
    chk(lines_done >= 8, "R3 lines streamed", lines_done, 8);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule